// File: doc/BRIEF.md
# Banked DMA Channel Register File

This block is the control and status register file of a 20-channel DMA engine. All of its registers sit on a simple 32-bit register bus. Software does not see a separate register set for each channel. It first writes a channel number into a select register. After that, one shared window of per-channel offsets reads and writes that channel's own control word, descriptor ring base, descriptor count, pending-interrupt status and interrupt enable. Port control works the same way, through a port select register and a port control window.

Each channel drives one interrupt line. The line is high when the channel's descriptor-complete status is pending, that cause is enabled in the channel's enable register, and the channel's bit is set in the global interrupt mask.

A channel reset requested through the control word runs for a fixed number of cycles. While it runs, the request bit reads back as 1, and it clears by itself when the reset ends. A bit in the global control register returns the whole block to its reset state. The block does not fetch descriptors, move data or arbitrate.

Top module: `dma_csr_bank`

## Requirements
- R1: Offsets 0x1C, 0x20, 0x24, 0x28 and 0x2C act only on the channel whose number was last written to the select register at 0x18. Reading 0x18 returns the stored select value (8 bits).
- R2: While the select register holds a value of 20 or more, reads of the banked offsets return 0 and writes to them change no channel. This also holds for values whose low 5 bits name a real channel.
- R3: In the channel control word at 0x1C, bit 0 is channel on, bit 8 is transmit direction and bits 17:16 are the weight, and these bits read back as written. Every other bit except bit 1 reads 0.
- R4: Writing 1 to control bit 1 starts a channel reset. Bit 1 reads 1 for the 4 cycles after the write and 0 from then on. The reset clears the on bit and the pending status. It keeps the descriptor base, the descriptor count, the direction and the weight.
- R5: The descriptor base at 0x20 holds 32 bits and the descriptor count at 0x24 holds 16 bits; upper count bits read 0.
- R6: A pulse on `evt_done[n]` sets bit 3 of channel n's status at 0x28. The pulse is ignored while that channel is resetting. Writing 1 to status bit 3 clears it; for example, writing 0x7E clears it and writing 0x77 leaves it set.
- R7: The channel enable register at 0x2C stores bits 6:1, and all other bits read 0. `irq[n]` is high exactly when channel n's status bit 3, its enable bit 3 and global mask bit n are all 1.
- R8: The global interrupt mask at 0xF4 holds one bit per channel (bit n gates channel n), bits 31:20 read 0, and all bits are 0 after reset.
- R9: Writing 1 to bit 0 of the global control register at 0x10 returns every register of the block to its reset value. That register always reads 0.
- R10: The poll control register at 0x14 stores only bit 31 (polling enable) and bit 6 (divided poll clock). All other bits read 0.
- R11: Port control at 0x44 is banked by the port select register at 0x40 across 4 ports. It stores a 4-bit swap field at bits 11:8 and a drop enable at bit 6. While the port select is 4 or more, port control reads 0 and ignores writes.
- R12: Reads of offsets that hold no register return 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle, 0 when idle |
| evt_done | input | 20 | One pulse per descriptor-complete event, one bit per channel |
| irq | output | 20 | Interrupt line per channel |

## Verification
Read data is combinational, so the bench samples `bus_rdata` shortly after the falling edge in the same cycle it drives the read. A write takes effect at the next rising edge, so its result is checked from the following falling edge onward. An `evt_done` pulse is likewise visible one edge after it is driven, and `irq` follows the stored state with no added delay. The reset-busy bit is polled on each of the four falling edges after the write edge and expected to read 0 on the fifth.

// File: rtl/dma_csr_bank.sv
module dma_csr_bank #(
  parameter int NCH     = 20,
  parameter int NPORT   = 4,
  parameter int RST_CYC = 4,
  parameter int CNT_W   = 16,
  parameter int SEL_W   = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_we,
  input  logic [7:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic [NCH-1:0] evt_done,
  output logic [NCH-1:0] irq
);
  localparam int CHW = $clog2(NCH);
  localparam int PW  = $clog2(NPORT);
  localparam int RCW = $clog2(RST_CYC + 1);
  localparam logic [SEL_W-1:0] NCH_L   = SEL_W'(NCH);
  localparam logic [SEL_W-1:0] NPORT_L = SEL_W'(NPORT);

  localparam logic [7:0] A_GCTL = 8'h10, A_POLL = 8'h14, A_CSEL = 8'h18;
  localparam logic [7:0] A_CCTL = 8'h1C, A_BASE = 8'h20, A_CNT = 8'h24;
  localparam logic [7:0] A_STAT = 8'h28, A_IEN = 8'h2C, A_PSEL = 8'h40;
  localparam logic [7:0] A_PCTL = 8'h44, A_MASK = 8'hF4;

  logic wr, soft_rst, ch_ok, pt_ok;
  logic [SEL_W-1:0] csel, psel;
  logic [CHW-1:0] chi;
  logic [PW-1:0] pi;
  logic poll_en, poll_div;
  logic [NCH-1:0] mask_q, busy, pend;
  logic [NPORT-1:0][3:0] pswap;
  logic [NPORT-1:0] pdrop;
  logic [31:0] rd_cctl [NCH];
  logic [31:0] rd_base [NCH];
  logic [31:0] rd_cnt  [NCH];
  logic [31:0] rd_stat [NCH];
  logic [31:0] rd_ien  [NCH];

  assign wr       = bus_sel & bus_we;
  assign soft_rst = wr && bus_addr == A_GCTL && bus_wdata[0];
  assign ch_ok    = csel < NCH_L;
  assign pt_ok    = psel < NPORT_L;
  assign chi      = csel[CHW-1:0];
  assign pi       = psel[PW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csel <= '0; psel <= '0; poll_en <= 1'b0; poll_div <= 1'b0;
      mask_q <= '0; pswap <= '0; pdrop <= '0;
    end else if (soft_rst) begin
      csel <= '0; psel <= '0; poll_en <= 1'b0; poll_div <= 1'b0;
      mask_q <= '0; pswap <= '0; pdrop <= '0;
    end else if (wr) begin
      case (bus_addr)
        A_CSEL: csel <= bus_wdata[SEL_W-1:0];
        A_PSEL: psel <= bus_wdata[SEL_W-1:0];
        A_POLL: begin poll_en <= bus_wdata[31]; poll_div <= bus_wdata[6]; end
        A_MASK: mask_q <= bus_wdata[NCH-1:0];
        A_PCTL: if (pt_ok) begin
          pswap[pi] <= bus_wdata[11:8];
          pdrop[pi] <= bus_wdata[6];
        end
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic on_q, tx_q, pend_q, hit, go;
    logic [1:0] wgt_q;
    logic [31:0] base_q;
    logic [CNT_W-1:0] cnt_q;
    logic [6:1] ien_q;
    logic [RCW-1:0] rc_q;

    assign hit = wr && ch_ok && (chi == CHW'(i));
    assign go  = hit && bus_addr == A_CCTL && bus_wdata[1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        on_q <= 1'b0; tx_q <= 1'b0; pend_q <= 1'b0; wgt_q <= '0;
        base_q <= '0; cnt_q <= '0; ien_q <= '0; rc_q <= '0;
      end else if (soft_rst) begin
        on_q <= 1'b0; tx_q <= 1'b0; pend_q <= 1'b0; wgt_q <= '0;
        base_q <= '0; cnt_q <= '0; ien_q <= '0; rc_q <= '0;
      end else begin
        if (go) rc_q <= RCW'(RST_CYC);
        else if (rc_q != '0) rc_q <= rc_q - 1'b1;

        if (hit && bus_addr == A_CCTL) begin
          tx_q  <= bus_wdata[8];
          wgt_q <= bus_wdata[17:16];
        end

        if (go || rc_q != '0) on_q <= 1'b0;
        else if (hit && bus_addr == A_CCTL) on_q <= bus_wdata[0];

        if (go || rc_q != '0) pend_q <= 1'b0;
        else if (evt_done[i]) pend_q <= 1'b1;
        else if (hit && bus_addr == A_STAT && bus_wdata[3]) pend_q <= 1'b0;

        if (hit && bus_addr == A_BASE) base_q <= bus_wdata;
        if (hit && bus_addr == A_CNT)  cnt_q  <= bus_wdata[CNT_W-1:0];
        if (hit && bus_addr == A_IEN)  ien_q  <= bus_wdata[6:1];
      end
    end

    assign busy[i]    = rc_q != '0;
    assign pend[i]    = pend_q;
    assign irq[i]     = pend_q & ien_q[3] & mask_q[i];
    assign rd_cctl[i] = {14'b0, wgt_q, 7'b0, tx_q, 6'b0, busy[i], on_q};
    assign rd_base[i] = base_q;
    assign rd_cnt[i]  = 32'(cnt_q);
    assign rd_stat[i] = {28'b0, pend_q, 3'b0};
    assign rd_ien[i]  = {25'b0, ien_q, 1'b0};
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      case (bus_addr)
        A_POLL: bus_rdata = {poll_en, 24'b0, poll_div, 6'b0};
        A_CSEL: bus_rdata = 32'(csel);
        A_PSEL: bus_rdata = 32'(psel);
        A_MASK: bus_rdata = 32'(mask_q);
        A_PCTL: if (pt_ok) bus_rdata = {20'b0, pswap[pi], 1'b0, pdrop[pi], 6'b0};
        A_CCTL: if (ch_ok) bus_rdata = rd_cctl[chi];
        A_BASE: if (ch_ok) bus_rdata = rd_base[chi];
        A_CNT:  if (ch_ok) bus_rdata = rd_cnt[chi];
        A_STAT: if (ch_ok) bus_rdata = rd_stat[chi];
        A_IEN:  if (ch_ok) bus_rdata = rd_ien[chi];
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

module dma_csr_bank_chk #(
  parameter int NCH   = 20,
  parameter int SEL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [7:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic [NCH-1:0]   evt_done,
  input logic [NCH-1:0]   irq,
  input logic [NCH-1:0]   busy,
  input logic [NCH-1:0]   pend,
  input logic [SEL_W-1:0] csel
);
  localparam int CHW = $clog2(NCH);
  localparam logic [SEL_W-1:0] NCH_L = SEL_W'(NCH);

  logic gwr, rst_req, banked, clr_any;
  logic [NCH-1:0] live;
  assign gwr     = bus_sel && bus_we && bus_addr == 8'h10 && bus_wdata[0];
  assign rst_req = bus_sel && bus_we && bus_addr == 8'h1C && bus_wdata[1] && csel < NCH_L;
  assign banked  = bus_addr == 8'h1C || bus_addr == 8'h20 || bus_addr == 8'h24 ||
                   bus_addr == 8'h28 || bus_addr == 8'h2C;
  assign clr_any = gwr || (bus_sel && bus_we && bus_addr == 8'h1C && bus_wdata[1]);
  assign live    = evt_done & ~busy;

  p_global_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gwr |=> irq == '0);

  p_reset_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> busy[$past(csel[CHW-1:0])]);

  p_oob_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && banked && csel >= NCH_L) |-> bus_rdata == '0);

  p_event_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live != '0 && !clr_any) |=> ((pend & $past(live)) == $past(live)));
endmodule

bind dma_csr_bank dma_csr_bank_chk #(.NCH(NCH), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .evt_done(evt_done), .irq(irq), .busy(busy), .pend(pend), .csel(csel)
);

// File: tb/sim_dma_csr_bank.sv
module sim_dma_csr_bank;
  localparam int NCH = 20;
  localparam logic [7:0] GCTL = 8'h10, POLL = 8'h14, CSEL = 8'h18, CCTL = 8'h1C;
  localparam logic [7:0] BASE = 8'h20, CNT = 8'h24, STAT = 8'h28, IEN = 8'h2C;
  localparam logic [7:0] PSEL = 8'h40, PCTL = 8'h44, MASK = 8'hF4;

  // entry: {req[3:0], is_read, addr[7:0], data[31:0]}; data = wdata or expected
  localparam int NV = 40;
  localparam logic [44:0] VEC [NV] = '{
    {4'd1,  1'b0, CSEL, 32'd5},
    {4'd3,  1'b0, CCTL, 32'hFFFF_FFFD},
    {4'd3,  1'b1, CCTL, 32'h0003_0101},        // R3
    {4'd5,  1'b0, BASE, 32'hDEAD_BEEF},
    {4'd5,  1'b1, BASE, 32'hDEAD_BEEF},        // R5
    {4'd5,  1'b0, CNT,  32'h0001_2345},
    {4'd5,  1'b1, CNT,  32'h0000_2345},
    {4'd1,  1'b0, CSEL, 32'd6},
    {4'd1,  1'b1, CSEL, 32'd6},                // R1
    {4'd1,  1'b1, CCTL, 32'h0},
    {4'd1,  1'b1, BASE, 32'h0},
    {4'd1,  1'b0, BASE, 32'h0102_0304},
    {4'd1,  1'b0, CSEL, 32'd5},
    {4'd1,  1'b1, BASE, 32'hDEAD_BEEF},
    {4'd10, 1'b0, POLL, 32'hFFFF_FFFF},
    {4'd10, 1'b1, POLL, 32'h8000_0040},        // R10
    {4'd11, 1'b0, PSEL, 32'd1},
    {4'd11, 1'b0, PCTL, 32'hFFFF_FFFF},
    {4'd11, 1'b1, PCTL, 32'h0000_0F40},        // R11
    {4'd11, 1'b0, PSEL, 32'd2},
    {4'd11, 1'b1, PCTL, 32'h0},
    {4'd11, 1'b0, PSEL, 32'd7},
    {4'd11, 1'b0, PCTL, 32'hFFFF_FFFF},
    {4'd11, 1'b1, PCTL, 32'h0},
    {4'd11, 1'b0, PSEL, 32'd1},
    {4'd11, 1'b1, PCTL, 32'h0000_0F40},
    {4'd8,  1'b0, MASK, 32'hFFFF_FFFF},
    {4'd8,  1'b1, MASK, 32'h000F_FFFF},        // R8
    {4'd12, 1'b0, 8'h30, 32'hFFFF_FFFF},
    {4'd12, 1'b1, 8'h30, 32'h0},               // R12
    {4'd2,  1'b0, CSEL, 32'h24},
    {4'd2,  1'b1, CSEL, 32'h24},               // R2
    {4'd2,  1'b0, BASE, 32'hAAAA_5555},
    {4'd2,  1'b1, BASE, 32'h0},
    {4'd2,  1'b0, CSEL, 32'd4},
    {4'd2,  1'b1, BASE, 32'h0},
    {4'd7,  1'b0, CSEL, 32'd5},
    {4'd7,  1'b0, IEN,  32'hFFFF_FFFF},
    {4'd7,  1'b1, IEN,  32'h0000_007E},        // R7
    {4'd9,  1'b1, GCTL, 32'h0}                 // R9
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] evt_done = '0;
  logic [NCH-1:0] irq;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_csr_bank u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_done(evt_done), .irq(irq));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 chk(tag, bus_rdata, exp);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic pulse(logic [NCH-1:0] v);
    evt_done = v;
    @(negedge clk);
    evt_done = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    rd(MASK, 32'h0, "R8 mask after reset");
    rd(CSEL, 32'h0, "R1 select after reset");
    rd(STAT, 32'h0, "R6 status after reset");
    #1 chk("R7 irq after reset", 32'(irq), 32'h0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][40]) rd(VEC[k][39:32], VEC[k][31:0], $sformatf("R%0d vector %0d", VEC[k][44:41], k));
      else            wr(VEC[k][39:32], VEC[k][31:0]);
    end

    // R4: channel reset timing, channel 5 selected, weight/tx set
    wr(CCTL, 32'h0003_0103);
    for (int c = 0; c < 4; c++) rd(CCTL, 32'h0003_0102, $sformatf("R4 busy cycle %0d", c));
    rd(CCTL, 32'h0003_0100, "R4 reset done");
    rd(BASE, 32'hDEAD_BEEF, "R4 base kept");
    rd(CNT,  32'h0000_2345, "R4 count kept");

    // R6 / R7 event, acknowledge, gating
    pulse(NCH'(1) << 5);
    rd(STAT, 32'h8, "R6 event sets status");
    #1 chk("R7 irq raised", 32'(irq), 32'h20);
    wr(STAT, 32'h77);
    rd(STAT, 32'h8, "R6 write without bit3 keeps");
    wr(IEN, 32'h0);
    #1 chk("R7 irq off when cause disabled", 32'(irq[5]), 32'h0);
    wr(IEN, 32'h8);
    #1 chk("R7 irq back on", 32'(irq[5]), 32'h1);
    wr(MASK, 32'hFFFF_FFDF);
    #1 chk("R8 mask gates irq", 32'(irq[5]), 32'h0);
    wr(MASK, 32'hFFFF_FFFF);
    wr(STAT, 32'h7E);
    rd(STAT, 32'h0, "R6 ack clears");
    #1 chk("R7 irq cleared", 32'(irq), 32'h0);

    pulse(NCH'(1) << 5);
    wr(CCTL, 32'h2);
    rd(STAT, 32'h0, "R4 reset clears status");
    wr(CCTL, 32'h2);
    pulse(NCH'(1) << 5);
    repeat (6) @(negedge clk);
    rd(STAT, 32'h0, "R6 event ignored during reset");

    // R9 global reset
    wr(BASE, 32'h1234_5678);
    pulse(NCH'(1) << 5);
    wr(GCTL, 32'h1);
    #1 chk("R9 irq after soft reset", 32'(irq), 32'h0);
    rd(MASK, 32'h0, "R9 mask cleared");
    rd(CSEL, 32'h0, "R9 select cleared");
    rd(POLL, 32'h0, "R9 poll cleared");
    wr(CSEL, 32'd5);
    rd(BASE, 32'h0, "R9 base cleared");
    rd(CCTL, 32'h0, "R9 control cleared");
    wr(PSEL, 32'd1);
    rd(PCTL, 32'h0, "R9 port control cleared");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule